// File: doc/BRIEF.md
# SPI Serial EEPROM Command Controller

This block is the slave-side serial front end of a byte-wide non-volatile memory, with the array held as an internal register array. A fast system clock samples the serial clock, chip select, data input and pause inputs. An opcode byte comes in first, most significant bit first, and is followed where needed by a 16-bit address and by data. Six commands are decoded: array read, array write, write-enable latch set, write-enable latch clear, status read and status write. Reads stream bytes out one after another. Writes fill a page buffer. A self-timed programming period then copies the buffer into the array.

A separate protect unit decides whether a write may proceed. It sees the current write address and the three stored protection bits, and it returns a single grant level that is sampled when chip select rises. The array depth, the page size and the programming time are parameters. The full device uses a 14-bit array address and 64-byte pages. The default here is a 10-bit array address, which keeps the elaborated memory small.

Top module: `spiEepromCtrl`

## Requirements
- R1: While chip select is high, the serial output enable is low and the data input has no effect. After reset, a status read returns 0x00.
- R2: Opcodes are matched on bits 7:4 = 0 and bits 2:0, with bit 3 ignored: 011 read, 010 write, 110 latch set, 100 latch clear, 101 status read, 001 status write.
- R3: Any other opcode leaves the output disabled and ignores every remaining bit until chip select is raised and lowered again.
- R4: A read takes a 16-bit address, of which only the low array-width bits count. It outputs bytes from there, most significant bit first, incrementing after each byte and wrapping from the top address to 0.
- R5: Status bit 1 shows the write-enable latch. The latch-set command sets it and the latch-clear command clears it. A write or status write issued while the latch is clear is ignored.
- R6: A write stores its data bytes at successive offsets inside the addressed page. Past the page end the offset wraps to the page start, and the last byte sent to an offset wins.
- R7: Programming is requested only when chip select rises after a whole data byte and before any further serial clock rise. Otherwise the write is discarded and the latch is kept. A requested program clears the latch.
- R8: During programming, a status read returns 0xFF and every other command is ignored. After BUSY_CYC system cycles the data is in the array and status bit 0 reads 0.
- R9: Pulling the pause input low while the serial clock is low freezes the transfer. Clock edges are then ignored and the output is disabled. Raising it again while the clock is low resumes the transfer exactly where it stopped.
- R10: A status write stores its data bits 7, 3 and 2. They appear on protBits as {bit7, bit3, bit2} and at the same positions in a status read.
- R11: If wrGrant is low when a write would start programming, nothing is stored, no busy period begins, and the latch is still cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| spiSck | input | 1 | Serial clock from the master |
| spiCsN | input | 1 | Active-low chip select |
| spiSi | input | 1 | Serial data in |
| spiHoldN | input | 1 | Active-low transfer pause |
| wrGrant | input | 1 | Permission from the protect unit, sampled at chip-select rise |
| spiSo | output | 1 | Serial data out |
| spiSoEn | output | 1 | Output driver enable (high-impedance when low) |
| protBits | output | 3 | Stored protection bits {bit7, bit3, bit2} |
| reqAddr | output | ADDR_W | Current array address, used by the protect unit |

## Verification
The bench builds the block with a 10-bit array address, 64-byte pages and a 600-cycle programming time. The short busy period lets the bench run several program cycles within the run, and a status poll still lands inside the busy window. The 1024-byte array lets a read run past the top address and wrap. A 70-byte write wraps the page offset. The page size equals the full device's page size, so the wrap point is the one that matters.

// File: rtl/eeSpiPkg.sv
package eeSpiPkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_OPC, PH_ADDR, PH_WDATA, PH_SDATA, PH_OUT, PH_SKIP
  } phase_t;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic sample;       // shift one SI bit in
    logic addrLoad;     // capture assembled address
    logic bufClear;     // empty the page buffer
    logic bufWrite;     // store received byte in page buffer
    logic statLoad;     // store received status byte
    logic outLoadMem;   // load first array byte for output
    logic outLoadStat;  // load status byte for output
    logic outShift;     // advance output on serial clock fall
    logic commitArray;  // copy page buffer into array
    logic commitStatus; // copy pending status bits
    logic wen;          // write-enable latch
    logic busy;         // programming in progress
  } strobe_t;

endpackage

// File: rtl/eeSpiFront.sv
module eeSpiFront #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic csNIn,
  input  logic siIn,
  input  logic holdNIn,
  output logic sckRise,
  output logic sckFall,
  output logic csFall,
  output logic csRise,
  output logic csLive,
  output logic siBit,
  output logic held
);
  localparam int LANES = 4;
  localparam logic [LANES-1:0] IDLE_LVL = 4'b1010; // {holdN, si, csN, sck}

  logic [LANES-1:0] rawIn, syncd, lastLvl;
  assign rawIn = {holdNIn, siIn, csNIn, sckIn};

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= {STAGES{IDLE_LVL[g]}};
      else       pipe <= {pipe[STAGES-2:0], rawIn[g]};
    end
    assign syncd[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastLvl <= IDLE_LVL;
    else       lastLvl <= syncd;
  end

  logic holdFall, holdRise;
  assign holdFall = !syncd[3] && lastLvl[3];
  assign holdRise = syncd[3] && !lastLvl[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) held <= 1'b0;
    else if (holdFall && !syncd[0]) held <= 1'b1;
    else if (holdRise && !syncd[0]) held <= 1'b0;
  end

  assign csLive  = !syncd[1];
  assign csFall  = !syncd[1] && lastLvl[1];
  assign csRise  = syncd[1] && !lastLvl[1];
  assign sckRise = syncd[0] && !lastLvl[0] && csLive && !held;
  assign sckFall = !syncd[0] && lastLvl[0] && csLive && !held;
  assign siBit   = syncd[2];
endmodule

// File: rtl/eeSpiCtrl.sv
module eeSpiCtrl
  import eeSpiPkg::*;
#(
  parameter int BUSY_CYC = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckRise,
  input  logic       sckFall,
  input  logic       csFall,
  input  logic       csRise,
  input  logic       wrGrant,
  input  logic [7:0] rxByte,
  output strobe_t    st,
  output logic       outActive
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  phase_t phase;
  logic [2:0] bitCnt;
  logic addrHi, isWrite, commitReady, isStatus, pendStatus, wen, busy;
  logic [CNT_W-1:0] busyCnt;

  logic byteDone, busyEnd, opRead, opWrite, opSet, opClr, opRdsr, opWrsr;
  assign byteDone = sckRise && bitCnt == 3'd7;
  assign busyEnd  = busy && busyCnt == CNT_W'(BUSY_CYC - 1);
  assign opRead   = (rxByte & 8'hF7) == 8'h03;
  assign opWrite  = (rxByte & 8'hF7) == 8'h02;
  assign opSet    = (rxByte & 8'hF7) == 8'h06;
  assign opClr    = (rxByte & 8'hF7) == 8'h04;
  assign opRdsr   = (rxByte & 8'hF7) == 8'h05;
  assign opWrsr   = (rxByte & 8'hF7) == 8'h01;
  assign outActive = phase == PH_OUT;

  always_comb begin
    st = '0;
    st.wen  = wen;
    st.busy = busy;
    st.sample = sckRise && (phase == PH_OPC || phase == PH_ADDR ||
                            phase == PH_WDATA || phase == PH_SDATA);
    if (byteDone) begin
      unique case (phase)
        PH_OPC: begin
          st.bufClear    = !busy && opWrite && wen;
          st.outLoadStat = opRdsr;
        end
        PH_ADDR: begin
          st.addrLoad   = addrHi;
          st.outLoadMem = addrHi && !isWrite;
        end
        PH_WDATA: st.bufWrite = 1'b1;
        PH_SDATA: st.statLoad = 1'b1;
        default: ;
      endcase
    end
    st.outShift     = sckFall && phase == PH_OUT;
    st.commitArray  = busyEnd && !pendStatus;
    st.commitStatus = busyEnd && pendStatus;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE; bitCnt <= '0; addrHi <= 1'b0; isWrite <= 1'b0;
      commitReady <= 1'b0; isStatus <= 1'b0; pendStatus <= 1'b0;
      wen <= 1'b0; busy <= 1'b0; busyCnt <= '0;
    end else begin
      if (busy) begin
        busyCnt <= busyCnt + 1'b1;
        if (busyEnd) busy <= 1'b0;
      end
      if (csFall) begin
        phase <= PH_OPC; bitCnt <= '0; commitReady <= 1'b0;
      end else if (csRise) begin
        phase <= PH_IDLE;
        commitReady <= 1'b0;
        if (commitReady) begin
          wen <= 1'b0;
          if (wrGrant) begin
            busy <= 1'b1; busyCnt <= '0; pendStatus <= isStatus;
          end
        end
      end else begin
        if (sckRise) begin
          bitCnt <= bitCnt + 1'b1;
          commitReady <= 1'b0;
        end
        if (byteDone) begin
          unique case (phase)
            PH_OPC: begin
              addrHi <= 1'b0;
              if (busy)                 phase <= opRdsr ? PH_OUT : PH_SKIP;
              else if (opRead)          begin phase <= PH_ADDR; isWrite <= 1'b0; end
              else if (opWrite && wen)  begin phase <= PH_ADDR; isWrite <= 1'b1; end
              else if (opWrsr && wen)   phase <= PH_SDATA;
              else if (opRdsr)          phase <= PH_OUT;
              else if (opSet)           begin wen <= 1'b1; phase <= PH_SKIP; end
              else if (opClr)           begin wen <= 1'b0; phase <= PH_SKIP; end
              else                      phase <= PH_SKIP;
            end
            PH_ADDR: begin
              addrHi <= !addrHi;
              if (addrHi) phase <= isWrite ? PH_WDATA : PH_OUT;
            end
            PH_WDATA: begin commitReady <= 1'b1; isStatus <= 1'b0; end
            PH_SDATA: begin commitReady <= 1'b1; isStatus <= 1'b1; phase <= PH_SKIP; end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/eeSpiDatapath.sv
module eeSpiDatapath
  import eeSpiPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic              siBit,
  output logic [7:0]        rxByte,
  output logic              soBit,
  output logic [2:0]        protBits,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int SHIFT_W    = (ADDR_W > 8) ? ADDR_W : 8;

  logic [SHIFT_W-2:0] shiftReg;
  logic [SHIFT_W-1:0] rxWord;
  assign rxWord = {shiftReg, siBit};
  assign rxByte = rxWord[7:0];

  logic [ADDR_W-1:0] addr, rxAddr;
  assign rxAddr  = rxWord[ADDR_W-1:0];
  assign curAddr = addr;

  logic [7:0] mem [DEPTH];
  logic [7:0] pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageValid;
  logic [7:0] outReg;
  logic [2:0] outCnt, statPend, statBits;
  logic outIsStat, soReg;
  logic [7:0] statusByte;

  assign statusByte = st.busy ? 8'hFF :
                      {statBits[2], 3'b000, statBits[1:0], st.wen, 1'b0};
  assign protBits = statBits;
  assign soBit    = soReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0; addr <= '0; pageValid <= '0; outReg <= '0;
      outCnt <= '0; outIsStat <= 1'b0; soReg <= 1'b0;
      statPend <= '0; statBits <= '0;
    end else begin
      if (st.sample) shiftReg <= rxWord[SHIFT_W-2:0];
      if (st.addrLoad) addr <= st.outLoadMem ? rxAddr + 1'b1 : rxAddr;
      if (st.bufClear) pageValid <= '0;
      if (st.bufWrite) begin
        pageValid[addr[PAGE_W-1:0]] <= 1'b1;
        addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
      end
      if (st.statLoad) statPend <= {rxByte[7], rxByte[3], rxByte[2]};
      if (st.commitStatus) statBits <= statPend;
      if (st.outLoadMem) begin
        outReg <= mem[rxAddr]; outCnt <= '0; outIsStat <= 1'b0;
      end else if (st.outLoadStat) begin
        outReg <= statusByte; outCnt <= '0; outIsStat <= 1'b1;
      end else if (st.outShift) begin
        soReg  <= outReg[7];
        outCnt <= outCnt + 1'b1;
        if (outCnt == 3'd7) begin
          if (outIsStat) outReg <= statusByte;
          else begin
            outReg <= mem[addr];
            addr   <= addr + 1'b1;
          end
        end else begin
          outReg <= {outReg[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st.bufWrite) pageBuf[addr[PAGE_W-1:0]] <= rxByte;
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (st.commitArray && pageValid[i])
        mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
    end
  end
endmodule

// File: rtl/spiEepromCtrl.sv
module spiEepromCtrl
  import eeSpiPkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 6,
  parameter int BUSY_CYC = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSck,
  input  logic              spiCsN,
  input  logic              spiSi,
  input  logic              spiHoldN,
  input  logic              wrGrant,
  output logic              spiSo,
  output logic              spiSoEn,
  output logic [2:0]        protBits,
  output logic [ADDR_W-1:0] reqAddr
);
  logic sckRise, sckFall, csFall, csRise, csLive, siBit, held, outActive;
  logic [7:0] rxByte;
  strobe_t st;

  eeSpiFront #(.STAGES(2)) uFront (
    .clk(clk), .rstN(rstN), .sckIn(spiSck), .csNIn(spiCsN), .siIn(spiSi),
    .holdNIn(spiHoldN), .sckRise(sckRise), .sckFall(sckFall), .csFall(csFall),
    .csRise(csRise), .csLive(csLive), .siBit(siBit), .held(held)
  );

  eeSpiCtrl #(.BUSY_CYC(BUSY_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .sckRise(sckRise), .sckFall(sckFall),
    .csFall(csFall), .csRise(csRise), .wrGrant(wrGrant), .rxByte(rxByte),
    .st(st), .outActive(outActive)
  );

  eeSpiDatapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uData (
    .clk(clk), .rstN(rstN), .st(st), .siBit(siBit), .rxByte(rxByte),
    .soBit(spiSo), .protBits(protBits), .curAddr(reqAddr)
  );

  assign spiSoEn = csLive && outActive && !held;
endmodule

// File: rtl/eeSpiChecker.sv
module eeSpiChecker
  import eeSpiPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              csLive,
  input logic              held,
  input logic              spiSoEn,
  input logic              wrGrant,
  input strobe_t           st,
  input logic [ADDR_W-1:0] reqAddr
);
  assert_so_off_deselect_R1: assert property (@(posedge clk) disable iff (!rstN)
    !csLive |-> !spiSoEn);

  assert_hold_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    held |-> !spiSoEn);

  assert_busy_no_intake_R8: assert property (@(posedge clk) disable iff (!rstN)
    st.busy |-> !(st.bufWrite || st.bufClear || st.addrLoad || st.outLoadMem));

  assert_latch_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(st.busy) |-> !st.wen);

  assert_page_fixed_R6: assert property (@(posedge clk) disable iff (!rstN)
    st.bufWrite |=> $stable(reqAddr[ADDR_W-1:PAGE_W]));

  assert_grant_needed_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(st.busy) |-> $past(wrGrant));
endmodule

bind spiEepromCtrl eeSpiChecker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uChk (
  .clk(clk), .rstN(rstN), .csLive(csLive), .held(held), .spiSoEn(spiSoEn),
  .wrGrant(wrGrant), .st(st), .reqAddr(reqAddr)
);

// File: tb/tb_spiEepromCtrl.sv
`timescale 1ns/1ps
module tb_spiEepromCtrl;
  localparam int ADDR_W = 10, PAGE_W = 6, BUSY_CYC = 600;
  localparam int DEPTH = 1 << ADDR_W, HALF = 6;

  logic clk = 0, rstN = 0;
  logic spiSck = 0, spiCsN = 1, spiSi = 0, spiHoldN = 1, wrGrant = 1;
  logic spiSo, spiSoEn;
  logic [2:0] protBits;
  logic [ADDR_W-1:0] reqAddr;

  always #2 clk = ~clk;

  spiEepromCtrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUSY_CYC(BUSY_CYC)) dut (
    .clk(clk), .rstN(rstN), .spiSck(spiSck), .spiCsN(spiCsN), .spiSi(spiSi),
    .spiHoldN(spiHoldN), .wrGrant(wrGrant), .spiSo(spiSo), .spiSoEn(spiSoEn),
    .protBits(protBits), .reqAddr(reqAddr)
  );

  int nChecks = 0, nFail = 0;
  bit done = 0, sawEn = 0;
  logic [7:0] model [DEPTH];
  bit known [DEPTH];
  logic [7:0] wbuf [80];

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic csLow();
    spiCsN = 0; sawEn = 0; waitClk(HALF);
  endtask

  task automatic csHigh();
    waitClk(HALF); spiCsN = 1; waitClk(2 * HALF);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spiSi = tx[i];
      waitClk(HALF);
      rx[i] = spiSo;
      if (spiSoEn) sawEn = 1;
      spiSck = 1; waitClk(HALF); spiSck = 0;
    end
  endtask

  task automatic oneByteCmd(input logic [7:0] op);
    logic [7:0] r;
    csLow(); xfer(op, r); csHigh();
  endtask

  task automatic readStatus(output logic [7:0] s);
    logic [7:0] r;
    csLow(); xfer(8'h05, r); xfer(8'h00, s); csHigh();
  endtask

  task automatic readCheck(input string tag, input logic [7:0] op,
                           input logic [15:0] a, input int n);
    logic [7:0] r;
    csLow(); xfer(op, r); xfer(a[15:8], r); xfer(a[7:0], r);
    for (int i = 0; i < n; i++) begin
      int ad = (int'(a) + i) % DEPTH;
      xfer(8'h00, r);
      if (known[ad]) check(tag, r, model[ad]);
    end
    csHigh();
  endtask

  task automatic pageWrite(input logic [15:0] a, input int n, input int extraBits);
    logic [7:0] r;
    csLow(); xfer(8'h02, r); xfer(a[15:8], r); xfer(a[7:0], r);
    for (int i = 0; i < n; i++) xfer(wbuf[i], r);
    for (int i = 0; i < extraBits; i++) begin
      waitClk(HALF); spiSck = 1; waitClk(HALF); spiSck = 0;
    end
    csHigh();
  endtask

  function automatic void modelWrite(input int a, input int n);
    int base = a & ~((1 << PAGE_W) - 1);
    for (int i = 0; i < n; i++) begin
      int ad = base + (((a & ((1 << PAGE_W) - 1)) + i) % (1 << PAGE_W));
      model[ad] = wbuf[i]; known[ad] = 1;
    end
  endfunction

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      done = 1; nFail++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, r;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    waitClk(5); rstN = 1; waitClk(5);

    // R1 reset state
    check("R1 soEn idle", spiSoEn, 0);
    readStatus(s); check("R1 status after reset", s, 8'h00);

    // R5 latch set / clear
    oneByteCmd(8'h06); readStatus(s); check("R5 latch set", s, 8'h02);
    oneByteCmd(8'h04); readStatus(s); check("R5 latch clear", s, 8'h00);

    // R8 page write, busy window
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hA0 + 8'(i);
    oneByteCmd(8'h06); pageWrite(16'h0010, 4, 0); modelWrite(16'h0010, 4);
    readStatus(s); check("R8 status while busy", s, 8'hFF);
    csLow(); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h10, r); xfer(8'h00, r); csHigh();
    check("R8 read ignored while busy", sawEn, 0);
    waitClk(BUSY_CYC + 50);
    readStatus(s); check("R7 latch cleared after program", s, 8'h00);
    readCheck("R4 read back", 8'h03, 16'hFC10, 4);
    check("R1 soEn after deselect", spiSoEn, 0);

    // R5 write without latch is ignored
    for (int i = 0; i < 4; i++) wbuf[i] = 8'h55;
    pageWrite(16'h0010, 4, 0);
    readStatus(s); check("R5 no busy without latch", s, 8'h00);
    readCheck("R5 data unchanged", 8'h03, 16'h0010, 4);

    // R6 page offset wrap, 70 bytes starting at offset 60
    for (int i = 0; i < 70; i++) wbuf[i] = 8'(i * 3 + 1);
    oneByteCmd(8'h06); pageWrite(16'h007C, 70, 0); modelWrite(16'h007C, 70);
    waitClk(BUSY_CYC + 50);
    readCheck("R6 page wrap", 8'h03, 16'h0040, 64);

    // R7 off-boundary chip select rise discards the write
    for (int i = 0; i < 2; i++) wbuf[i] = 8'h3C;
    oneByteCmd(8'h06); pageWrite(16'h0010, 2, 3);
    readStatus(s); check("R7 discard keeps latch", s, 8'h02);
    readCheck("R7 discarded data", 8'h03, 16'h0010, 2);
    oneByteCmd(8'h04);

    // R11 grant low
    wrGrant = 0;
    for (int i = 0; i < 2; i++) wbuf[i] = 8'hE7;
    oneByteCmd(8'h06); pageWrite(16'h0011, 2, 0);
    readStatus(s); check("R11 no busy, latch cleared", s, 8'h00);
    wrGrant = 1;
    readCheck("R11 data unchanged", 8'h03, 16'h0011, 2);

    // R4 wrap at top of array
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    oneByteCmd(8'h06); pageWrite(16'h03FE, 2, 0); modelWrite(16'h03FE, 2);
    waitClk(BUSY_CYC + 50);
    wbuf[0] = 8'h33; wbuf[1] = 8'h44;
    oneByteCmd(8'h06); pageWrite(16'h0000, 2, 0); modelWrite(16'h0000, 2);
    waitClk(BUSY_CYC + 50);
    readCheck("R4 top wrap", 8'h03, 16'h03FE, 4);

    // R2 bit 3 ignored
    readCheck("R2 read with bit3", 8'h0B, 16'h0010, 2);
    oneByteCmd(8'h0E); readStatus(s); check("R2 latch set with bit3", s, 8'h02);
    oneByteCmd(8'h0C); readStatus(s); check("R2 latch clear with bit3", s, 8'h00);

    // R3 unknown opcode
    csLow(); xfer(8'h07, r); xfer(8'h06, r); xfer(8'h05, r); csHigh();
    check("R3 output stays off", sawEn, 0);
    readStatus(s); check("R3 trailing bits ignored", s, 8'h00);
    csLow(); xfer(8'h13, r); xfer(8'h03, r); csHigh();
    check("R3 high-nibble opcode off", sawEn, 0);

    // R9 pause in the middle of a read byte
    begin
      logic [7:0] got;
      csLow(); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h40, r);
      for (int i = 7; i >= 0; i--) begin
        spiSi = 0;
        waitClk(HALF);
        if (i == 4) begin
          spiHoldN = 0; waitClk(HALF);
          check("R9 output off in pause", spiSoEn, 0);
          for (int k = 0; k < 3; k++) begin
            spiSck = 1; waitClk(HALF); spiSck = 0; waitClk(HALF);
          end
          spiHoldN = 1; waitClk(HALF);
        end
        got[i] = spiSo;
        spiSck = 1; waitClk(HALF); spiSck = 0;
      end
      csHigh();
      check("R9 byte intact across pause", got, model[16'h0040]);
    end

    // R10 status write
    oneByteCmd(8'h06);
    csLow(); xfer(8'h01, r); xfer(8'hFF, r); csHigh();
    waitClk(BUSY_CYC + 50);
    check("R10 protBits", protBits, 3'b111);
    readStatus(s); check("R10 status read", s, 8'h8C);

    // random page writes
    for (int it = 0; it < 4; it++) begin
      int pg = $urandom % (DEPTH >> PAGE_W);
      int off = $urandom % (1 << PAGE_W);
      int len = 1 + $urandom % 40;
      for (int i = 0; i < len; i++) wbuf[i] = 8'($urandom);
      oneByteCmd(8'h06);
      pageWrite(16'((pg << PAGE_W) + off), len, 0);
      modelWrite((pg << PAGE_W) + off, len);
      waitClk(BUSY_CYC + 50);
      readCheck("R6 random page", 8'h03, 16'(pg << PAGE_W), 1 << PAGE_W);
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule